// File: doc/BRIEF.md
# Multiplexed LED Grid Scanner with Dimming

This block drives a common-cathode multiplexed LED panel. It reads segment data from a 14-byte display memory, two bytes per digit. It steps through the grids one slot at a time and drives the matching segment enables during each slot. The number of grids can be set from four to seven. Three pins are shared: each one carries a segment when its grid is not in use, and a grid enable when it is.

Brightness is set by a pulse-width code. The code picks how many sixteenths of each digit slot the segments stay lit. A global enable turns the whole display off without stopping the scan. After the last grid, one extra slot runs with every grid dark, for key scanning. A one-clock pulse marks the end of that slot and so the end of each frame.

A serial front end (not part of this block) writes the mode and the control code through single-cycle strobes. The display memory sits beside the block and answers a read in the same cycle it is asked.

Top module: `led_grid_scanner`

## Requirements
- R1: After reset the mode is 7 grids (code 11), the display is off and the width code is 0. All segment, grid and frame outputs are low and `shared_is_grid_o` is 3'b111. The first `frame_end_o` pulse appears exactly 16*STEP_CLKS clocks after reset is released.
- R2: Mode code m gives 4+m grids. `shared_is_grid_o[2]` (SG13/GR5) is set when there are at least 5 grids, `[1]` (SG12/GR6) at 6 or more, and `[0]` (SG11/GR7) at 7.
- R3: Digit k (0-based) lights grid k: `grid_o[k]` for k<4, `shared_o[2]` for k=4, `shared_o[1]` for k=5 and `shared_o[0]` for k=6. At most one grid is active at a time.
- R4: For digit k, byte A=mem[2k] and byte B=mem[2k+1]. `seg_o[7:0]`=A and `seg_o[9:8]`=B[1:0]. When the shared pins carry segments, `shared_o[0]`=B[2], `shared_o[1]`=B[3] and `shared_o[2]`=B[4].
- R5: A memory read is `ram_rd_o` high with `ram_addr_o`, and the data is taken in that same cycle. No read addresses a byte at or above 2 times the grid count.
- R6: Width codes 0..7 select 1, 2, 4, 10, 11, 12, 13 and 14 sixteenths. With the display on, segments are lit for w*STEP_CLKS-1 clocks in each digit slot.
- R7: Segment outputs are low in every cycle in which the driven grid pattern differs from the previous cycle.
- R8: After the last grid comes one slot with no grid active. `frame_end_o` is a one-clock pulse at the end of that slot, and the frame lasts (grids+1)*16*STEP_CLKS clocks.
- R9: `ctrl_i[3]` written with `ctrl_wr_i` turns the display on or off, and `ctrl_i[2:0]` is the width code. While the display is off, no grid and no segment is driven.
- R10: Writing a mode that differs from the current one turns the display off and restarts the scan in the dark slot, so `frame_end_o` follows 16*STEP_CLKS clocks after the write. Writing the current mode again changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 2 | Grid mode code |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_i | input | 4 | Bit 3 display on, bits 2..0 width code |
| ram_rd_o | output | 1 | Display memory read strobe |
| ram_addr_o | output | 4 | Display memory byte address |
| ram_data_i | input | 8 | Display memory read data, same cycle |
| seg_o | output | 10 | Dedicated segment enables SG1..SG10 |
| grid_o | output | 4 | Dedicated grid enables GR1..GR4 |
| shared_o | output | 3 | Shared pins: bit0 SG11/GR7, bit1 SG12/GR6, bit2 SG13/GR5 |
| shared_is_grid_o | output | 3 | Set where a shared pin acts as a grid |
| frame_end_o | output | 1 | One-clock pulse after the dark key slot |

## Verification
The assertions assume that the mode and control strobes are single-cycle and synchronous to the clock, and that reset is released in step with the clock. They also assume that the memory returns valid data in the same cycle as the read strobe. The stimulus changes inputs only on falling edges and holds each strobe for exactly one cycle. It models the memory as a combinational array with a nonzero first byte for every digit. It writes the mode before the control code, so each measured frame runs with a fixed configuration from its start.

// File: rtl/lgs_pkg.sv
package lgs_pkg;

  localparam int GRID_MAX       = 7;
  localparam int SEG_MAX        = 13;
  localparam int SHARED_N       = 3;
  localparam int STEPS_PER_SLOT = 16;
  localparam int ADDR_W         = 4;

  typedef logic [2:0] digit_t;

  // lit fraction of a slot in sixteenths, per width code
  function automatic logic [3:0] pulse_sixteenths(input logic [2:0] code);
    logic [3:0] w;
    case (code)
      3'd0:    w = 4'd1;
      3'd1:    w = 4'd2;
      3'd2:    w = 4'd4;
      3'd3:    w = 4'd10;
      3'd4:    w = 4'd11;
      3'd5:    w = 4'd12;
      3'd6:    w = 4'd13;
      default: w = 4'd14;
    endcase
    return w;
  endfunction

  function automatic digit_t grids_in_mode(input logic [1:0] m);
    return 3'd4 + {1'b0, m};
  endfunction

endpackage

// File: rtl/lgs_slot_timer.sv
module lgs_slot_timer
  import lgs_pkg::*;
#(
  parameter int SLOT_CLKS = 64,
  parameter int CNT_W     = $clog2(SLOT_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  digit_t           restart_key,
  input  digit_t           ngrid,
  output logic [CNT_W-1:0] cnt_o,
  output digit_t           digit_o,
  output logic             slot_last_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  digit_t           dig_q, dig_d;

  always_comb begin
    slot_last_o = (cnt_q == CNT_LAST);
    cnt_d       = cnt_q;
    dig_d       = dig_q;
    if (restart) begin
      cnt_d = '0;
      dig_d = restart_key;
    end else if (slot_last_o) begin
      cnt_d = '0;
      dig_d = (dig_q >= ngrid) ? '0 : dig_q + 3'd1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dig_q <= digit_t'(GRID_MAX);
    end else begin
      cnt_q <= cnt_d;
      dig_q <= dig_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign digit_o = dig_q;

endmodule

// File: rtl/lgs_fetch.sv
module lgs_fetch
  import lgs_pkg::*;
#(
  parameter int SLOT_CLKS = 64,
  parameter int CNT_W     = $clog2(SLOT_CLKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt,
  input  digit_t             digit,
  input  digit_t             ngrid,
  input  logic [7:0]         ram_data,
  output logic               rd_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [SEG_MAX-1:0] pattern_o
);

  localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(SLOT_CLKS - 2);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SLOT_CLKS - 1);

  digit_t     next_dig;
  logic       take_lo, take_hi;
  logic [7:0] lo_q, lo_d, hi_q, hi_d;

  // the next digit's two bytes are read in the last two clocks of a slot,
  // while the segments are dark for every width code
  always_comb begin
    next_dig = (digit >= ngrid) ? '0 : digit + 3'd1;
    take_lo  = (cnt == CNT_FIRST);
    take_hi  = (cnt == CNT_LAST);
    rd_o     = (take_lo || take_hi) && (next_dig < ngrid);
    addr_o   = {next_dig, take_hi};
    lo_d     = (rd_o && take_lo) ? ram_data : lo_q;
    hi_d     = (rd_o && take_hi) ? ram_data : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign pattern_o = {hi_q[4:0], lo_q};

endmodule

// File: rtl/lgs_drive.sv
module lgs_drive
  import lgs_pkg::*;
#(
  parameter int STEP_CLKS = 4,
  parameter int CNT_W     = $clog2(STEP_CLKS * STEPS_PER_SLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    cnt,
  input  digit_t              digit,
  input  digit_t              ngrid,
  input  logic                disp_on,
  input  logic [2:0]          wcode,
  input  logic [SEG_MAX-1:0]  pattern,
  input  logic                slot_last,
  output logic [9:0]          seg_o,
  output logic [3:0]          grid_o,
  output logic [SHARED_N-1:0] shared_o,
  output logic [SHARED_N-1:0] shared_is_grid_o,
  output logic                frame_end_o
);

  logic                valid, lit, frame_d;
  logic [CNT_W-1:0]    limit;
  logic [GRID_MAX-1:0] grids_d, grids_q;
  logic [SEG_MAX-1:0]  segs;
  logic [SHARED_N-1:0] role_d, shared_d;

  logic [9:0]          seg_q;
  logic [3:0]          grid_q;
  logic [SHARED_N-1:0] shared_q, role_q;
  logic                frame_q;

  always_comb begin
    valid   = disp_on && (digit < ngrid);
    grids_d = valid ? (GRID_MAX'(1) << digit) : '0;
    limit   = CNT_W'(int'(pulse_sixteenths(wcode)) * STEP_CLKS);
    // dark whenever the grid about to be driven differs from the one driven now
    lit     = valid && (grids_d == grids_q) && (cnt < limit);
    segs    = lit ? pattern : '0;
    frame_d = (digit >= ngrid) && slot_last;
  end

  for (genvar j = 0; j < SHARED_N; j++) begin : g_shared
    assign role_d[j]   = (ngrid >= digit_t'(GRID_MAX - j));
    assign shared_d[j] = role_d[j] ? grids_d[GRID_MAX-1-j] : segs[10+j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grids_q  <= '0;
      seg_q    <= '0;
      grid_q   <= '0;
      shared_q <= '0;
      role_q   <= '1;
      frame_q  <= 1'b0;
    end else begin
      grids_q  <= grids_d;
      seg_q    <= segs[9:0];
      grid_q   <= grids_d[3:0];
      shared_q <= shared_d;
      role_q   <= role_d;
      frame_q  <= frame_d;
    end
  end

  assign seg_o            = seg_q;
  assign grid_o           = grid_q;
  assign shared_o         = shared_q;
  assign shared_is_grid_o = role_q;
  assign frame_end_o      = frame_q;

endmodule

// File: rtl/led_grid_scanner.sv
module led_grid_scanner
  import lgs_pkg::*;
#(
  parameter int STEP_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr_i,
  input  logic [1:0]  mode_i,
  input  logic        ctrl_wr_i,
  input  logic [3:0]  ctrl_i,
  output logic        ram_rd_o,
  output logic [3:0]  ram_addr_o,
  input  logic [7:0]  ram_data_i,
  output logic [9:0]  seg_o,
  output logic [3:0]  grid_o,
  output logic [2:0]  shared_o,
  output logic [2:0]  shared_is_grid_o,
  output logic        frame_end_o
);

  localparam int SLOT_CLKS = STEP_CLKS * STEPS_PER_SLOT;
  localparam int CNT_W     = $clog2(SLOT_CLKS);

  logic [1:0] mode_q, mode_d;
  logic       on_q, on_d;
  logic [2:0] wcode_q, wcode_d;
  logic       mode_chg;
  digit_t     ngrid, restart_key;

  logic [CNT_W-1:0]   cnt;
  digit_t             digit;
  logic               slot_last;
  logic [SEG_MAX-1:0] pattern;

  always_comb begin
    mode_chg    = mode_wr_i && (mode_i != mode_q);
    mode_d      = mode_chg ? mode_i : mode_q;
    // a real mode change blanks; a control write in the same cycle still sets width
    on_d        = mode_chg ? 1'b0 : (ctrl_wr_i ? ctrl_i[3] : on_q);
    wcode_d     = ctrl_wr_i ? ctrl_i[2:0] : wcode_q;
    ngrid       = grids_in_mode(mode_q);
    restart_key = grids_in_mode(mode_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 2'b11;
      on_q    <= 1'b0;
      wcode_q <= 3'd0;
    end else begin
      mode_q  <= mode_d;
      on_q    <= on_d;
      wcode_q <= wcode_d;
    end
  end

  lgs_slot_timer #(.SLOT_CLKS(SLOT_CLKS), .CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (mode_chg),
    .restart_key (restart_key),
    .ngrid       (ngrid),
    .cnt_o       (cnt),
    .digit_o     (digit),
    .slot_last_o (slot_last)
  );

  lgs_fetch #(.SLOT_CLKS(SLOT_CLKS), .CNT_W(CNT_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt),
    .digit     (digit),
    .ngrid     (ngrid),
    .ram_data  (ram_data_i),
    .rd_o      (ram_rd_o),
    .addr_o    (ram_addr_o),
    .pattern_o (pattern)
  );

  lgs_drive #(.STEP_CLKS(STEP_CLKS), .CNT_W(CNT_W)) u_drive (
    .clk              (clk),
    .rst_n            (rst_n),
    .cnt              (cnt),
    .digit            (digit),
    .ngrid            (ngrid),
    .disp_on          (on_q),
    .wcode            (wcode_q),
    .pattern          (pattern),
    .slot_last        (slot_last),
    .seg_o            (seg_o),
    .grid_o           (grid_o),
    .shared_o         (shared_o),
    .shared_is_grid_o (shared_is_grid_o),
    .frame_end_o      (frame_end_o)
  );

endmodule

// File: rtl/lgs_checker.sv
module lgs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_wr_i,
  input logic [1:0] mode_i,
  input logic       ctrl_wr_i,
  input logic [1:0] mode_q,
  input logic       on_q,
  input logic       ram_rd_o,
  input logic [3:0] ram_addr_o,
  input logic [9:0] seg_o,
  input logic [3:0] grid_o,
  input logic [2:0] shared_o,
  input logic [2:0] shared_is_grid_o,
  input logic       frame_end_o
);

  logic [6:0]  all_grids;
  logic [12:0] all_segs;

  assign all_grids = {shared_o & shared_is_grid_o, grid_o};
  assign all_segs  = {shared_o & ~shared_is_grid_o, seg_o};

  AST_ONE_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_grids)); // R3

  AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (all_grids != $past(all_grids)) |-> (all_segs == '0)); // R7

  AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |=> (all_grids == '0 && all_segs == '0)); // R9

  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> !frame_end_o); // R8

  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_o |-> (ram_addr_o < (4'd8 + {1'b0, mode_q, 1'b0}))); // R5

  AST_ROLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    shared_is_grid_o inside {3'b000, 3'b100, 3'b110, 3'b111}); // R2

  AST_MODE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_i && mode_i != mode_q) |=> !on_q); // R10

  AST_MODE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_i && mode_i == mode_q && !ctrl_wr_i) |=> ($stable(on_q) && $stable(mode_q))); // R10

endmodule

bind led_grid_scanner lgs_checker u_chk (.*);

// File: tb/led_grid_scanner_test.sv
module led_grid_scanner_test;

  localparam int STEP = 4;
  localparam int SLOT = 16 * STEP;

  // {mode[1:0], code[2:0], sixteenths[3:0], grids[2:0], roles[2:0]}
  localparam logic [14:0] VEC [0:7] = '{
    {2'd3, 3'd0, 4'd1,  3'd7, 3'b111},
    {2'd0, 3'd7, 4'd14, 3'd4, 3'b000},
    {2'd1, 3'd3, 4'd10, 3'd5, 3'b100},
    {2'd2, 3'd5, 4'd12, 3'd6, 3'b110},
    {2'd3, 3'd2, 4'd4,  3'd7, 3'b111},
    {2'd0, 3'd1, 4'd2,  3'd4, 3'b000},
    {2'd2, 3'd4, 4'd11, 3'd6, 3'b110},
    {2'd1, 3'd6, 4'd13, 3'd5, 3'b100}
  };

  logic       clk, rst_n;
  logic       mode_wr_i, ctrl_wr_i;
  logic [1:0] mode_i;
  logic [3:0] ctrl_i;
  logic       ram_rd_o;
  logic [3:0] ram_addr_o;
  logic [7:0] ram_data_i;
  logic [9:0] seg_o;
  logic [3:0] grid_o;
  logic [2:0] shared_o, shared_is_grid_o;
  logic       frame_end_o;

  logic [7:0]  ram [0:13];
  logic [16:0] cap [1:512];
  logic        fe  [1:512];
  int          total, bad, rd_bad;
  bit          done;

  led_grid_scanner #(.STEP_CLKS(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_i(ctrl_i), .ram_rd_o(ram_rd_o),
    .ram_addr_o(ram_addr_o), .ram_data_i(ram_data_i), .seg_o(seg_o),
    .grid_o(grid_o), .shared_o(shared_o), .shared_is_grid_o(shared_is_grid_o),
    .frame_end_o(frame_end_o)
  );

  assign ram_data_i = (ram_addr_o < 4'd14) ? ram[ram_addr_o] : 8'h00;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk);
    mode_i = m; mode_wr_i = 1'b1;
    @(negedge clk);
    mode_wr_i = 1'b0;
  endtask

  task automatic write_ctrl(input logic [3:0] c);
    @(negedge clk);
    ctrl_i = c; ctrl_wr_i = 1'b1;
    @(negedge clk);
    ctrl_wr_i = 1'b0;
  endtask

  // waits for a frame pulse, then records one whole frame of outputs
  task automatic capture(input int ng);
    do @(negedge clk); while (!frame_end_o);
    for (int i = 1; i <= (ng + 1) * SLOT; i++) begin
      @(negedge clk);
      cap[i] = {shared_o, grid_o, seg_o};
      fe[i]  = frame_end_o;
      if (ram_rd_o && int'(ram_addr_o) >= 2 * ng) rd_bad++;
    end
  endtask

  function automatic logic [16:0] exp_pins(input int d, input int ng, input bit lit);
    logic [7:0]  a, b;
    logic [12:0] s;
    logic [3:0]  gr;
    logic [2:0]  mx;
    a  = lit ? ram[2*d] : 8'h00;
    b  = lit ? ram[2*d+1] : 8'h00;
    s  = {b[4:0], a};
    gr = (d < 4) ? 4'(1 << d) : 4'h0;
    for (int j = 0; j < 3; j++)
      mx[j] = (ng >= 7 - j) ? (d == 6 - j) : s[10+j];
    return {mx, gr, s[9:0]};
  endfunction

  function automatic int dark_frame_hits(input int ng);
    int n = 0;
    for (int i = 1; i <= (ng + 1) * SLOT; i++)
      if (cap[i] != '0) n++;
    return n;
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R8 act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    total = 0; bad = 0; rd_bad = 0; done = 0;
    for (int a = 0; a < 14; a++) ram[a] = 8'(a * 29 + 7) | 8'h01;
    mode_wr_i = 0; ctrl_wr_i = 0; mode_i = 0; ctrl_i = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk({shared_o, grid_o, seg_o, frame_end_o} == '0, "R1 outputs low in reset",
        {shared_o, grid_o, seg_o, frame_end_o}, 0);
    chk(shared_is_grid_o == 3'b111, "R1 shared roles in reset", shared_is_grid_o, 3'b111);
    rst_n = 1'b1;
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!frame_end_o);
    chk(n == SLOT, "R1 first frame pulse delay", n, SLOT);
    capture(7);
    chk(dark_frame_hits(7) == 0, "R1 display off after reset", dark_frame_hits(7), 0);

    // table walk: mode, width, mapping, key slot
    for (int v = 0; v < 8; v++) begin
      logic [1:0] m;  logic [2:0] code, rl;
      int w, ng, on_cnt, key_hits, fe_ok;
      {m, code} = VEC[v][14:10];
      w  = int'(VEC[v][9:6]);
      ng = int'(VEC[v][5:3]);
      rl = VEC[v][2:0];
      write_mode(m);
      write_ctrl({1'b1, code});
      capture(ng);
      chk(shared_is_grid_o == rl, "R2 shared pin roles", shared_is_grid_o, rl);
      for (int d = 0; d < ng; d++)
        chk(cap[d*SLOT+2] == exp_pins(d, ng, 1), "R3 R4 digit pins", cap[d*SLOT+2], exp_pins(d, ng, 1));
      chk(cap[SLOT+1] == exp_pins(1, ng, 0), "R7 dark clock at grid change", cap[SLOT+1], exp_pins(1, ng, 0));
      on_cnt = 0;
      for (int i = 1; i <= SLOT; i++) if (cap[i][9:0] != '0) on_cnt++;
      chk(on_cnt == w * STEP - 1, "R6 lit clocks per slot", on_cnt, w * STEP - 1);
      key_hits = 0;
      for (int i = ng * SLOT + 1; i <= (ng + 1) * SLOT; i++)
        if (cap[i][13:10] != '0 || (cap[i][16:14] & rl) != '0) key_hits++;
      chk(key_hits == 0, "R8 key slot dark", key_hits, 0);
      fe_ok = fe[(ng+1)*SLOT] ? 1 : 0;
      for (int i = 1; i < (ng + 1) * SLOT; i++) if (fe[i]) fe_ok = 0;
      chk(fe_ok == 1, "R8 frame length and pulse", fe_ok, 1);
      chk(rd_bad == 0, "R5 read address range", rd_bad, 0);
    end

    // R9: display off, scan keeps running, then back on
    write_ctrl(4'b0110);
    capture(5);
    chk(dark_frame_hits(5) == 0, "R9 display off dark", dark_frame_hits(5), 0);
    write_ctrl(4'b1110);

    // R10: same mode keeps the display lit
    write_mode(2'd1);
    capture(5);
    chk(cap[2] == exp_pins(0, 5, 1), "R10 same mode no effect", cap[2], exp_pins(0, 5, 1));

    // R10: new mode blanks and restarts in the dark slot
    write_mode(2'd0);
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!frame_end_o);
    chk(n == SLOT, "R10 restart into key slot", n, SLOT);
    capture(4);
    chk(dark_frame_hits(4) == 0, "R10 mode change blanks", dark_frame_hits(4), 0);
    chk(shared_is_grid_o == 3'b000, "R2 four grid roles", shared_is_grid_o, 3'b000);

    done = 1;
    summary();
    $finish;
  end

endmodule